// File: doc/BRIEF.md
# Multichannel ADC Read Controller

This block is the host side of a parallel link to an 8-bit multiplexed analog-to-digital converter. It drives an active-low chip-select, an active-low read strobe and a channel address. It watches the converter's ready line (pulled up, so it reads high when released) and its active-low end-of-conversion line. A pulse on `start_i` launches one scan over the channels whose bits are set in `scan_mask_i`. The channels are visited in ascending order, and each result leaves on a valid/ready stream, tagged with the channel it was converted from.

Two bus disciplines are supported, and `mode_i` picks one at the start of each scan. In the wait-state discipline the strobes stay low until the converter releases ready, and the word on the data bus is the fresh result. In the pipelined discipline every read is short. It returns the result of the conversion launched by the read before it, and it launches a new conversion on the address it presents. The controller therefore carries a one-read address delay. It drops the data of the first read and appends one flushing read after the last channel. Consecutive pipelined reads are kept apart by a cycle timer, or by waiting for the end-of-conversion line, chosen by a parameter. A stalled output stream holds off the next read. A converter that never answers aborts the scan and raises an error flag.

Top module: `adcrd_ctrl`

## Requirements
- R1: After reset `adc_cs_n_o` and `adc_rd_n_o` are high, and `smp_valid_o`, `busy_o` and `err_o` are low.
- R2: A scan visits the set bits of `scan_mask_i` (bit i selects channel i, which is presented as address value i) from lowest to highest. It delivers exactly one sample per selected channel, and `smp_chan_o` is the address under which that sample was converted.
- R3: `adc_addr_o` does not change while `adc_cs_n_o` is low.
- R4: With `mode_i`=0 a read keeps both strobes low for at least RD_CYC cycles and until `adc_rdy_i` is seen high. The data word is captured in that cycle and tagged with the address of the same read.
- R5: With `mode_i`=1 the data captured by each read is tagged with the address of the read before it. The data of the first read of a scan is dropped, and one extra read follows the last selected channel, so a scan of N channels makes N+1 reads and yields N samples.
- R6: When the previous read was pipelined, the next falling edge of `adc_rd_n_o` comes at least GAP_CYC clock cycles after the previous one (GAP_SRC=0). With GAP_SRC=1 it waits instead for `adc_int_n_i` low.
- R7: While `smp_valid_o` is high and `smp_ready_i` is low, the valid, data and channel outputs hold. No read starts while `smp_valid_o` is high, so no sample is lost.
- R8: If a wait-state read sees no high `adc_rdy_i` within TMO_CYC cycles (or, with GAP_SRC=1, `adc_int_n_i` stays high that long), the bus is released, `err_o` goes high and the block returns to idle. `err_o` clears on the next accepted start.
- R9: A `start_i` pulse with an all-zero mask, or one that arrives while `busy_o` is high, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that launches one scan |
| mode_i | input | 1 | 0 wait-state reads, 1 pipelined reads; latched at start |
| scan_mask_i | input | NCH | Channel selection, bit i for channel i; latched at start |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_addr_o | output | AW | Channel address presented to the converter |
| adc_data_i | input | DW | Converter data bus |
| adc_rdy_i | input | 1 | Converter ready, high when released |
| adc_int_n_i | input | 1 | Converter end-of-conversion, active low |
| smp_valid_o | output | 1 | Sample stream valid |
| smp_ready_i | input | 1 | Sample stream ready |
| smp_data_o | output | DW | Sample value |
| smp_chan_o | output | AW | Channel the sample was converted from |
| busy_o | output | 1 | A scan is in progress |
| err_o | output | 1 | The last scan was aborted by a timeout |

## Verification
The assertions assume that `adc_rdy_i` is driven low by the converter only while a read is in progress. They also assume the converter finishes each conversion in fewer than GAP_CYC cycles, so that spacing reads by the timer alone is safe. The bench's converter model follows both rules. It pulls ready low one cycle after the strobes fall, finishes a conversion in 200 cycles against a 250-cycle gap, and holds ready low only in the deliberate timeout scenario. The ready input of the stream is driven always high, toggling or held low, so the stall assertions are exercised and no stimulus pulses ready outside those patterns.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_GAP  = 2'd2
   } adcrd_state_e;
endpackage

// File: rtl/adcrd_chan_pick.sv
module adcrd_chan_pick #(
   parameter int NCH = 8,
   parameter int AW  = 3
) (
   input  logic [NCH-1:0] mask,
   input  logic [AW-1:0]  cur,
   input  logic           from_start,
   output logic [AW-1:0]  nxt,
   output logic           found
);
   // lowest selected channel above cur (or from zero when from_start)
   always_comb begin
      nxt   = '0;
      found = 1'b0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask[i] && (from_start || (i > int'(cur)))) begin
            nxt   = AW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/adcrd_gap.sv
module adcrd_gap #(
   parameter int GAP_CYC = 250,
   parameter int MIN_GAP = 2,
   parameter int TMO_CYC = 1000,
   parameter int GAP_SRC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic need_conv,
   input  logic int_n,
   output logic done,
   output logic tmo
);
   localparam int LIM = (GAP_CYC > TMO_CYC) ? GAP_CYC : TMO_CYC;
   localparam int GCW = $clog2(LIM + 2);
   localparam logic [GCW-1:0] CMAX = {GCW{1'b1}};

   logic [GCW-1:0] cnt_q;

   // counts cycles since the last read started; saturates so idle time counts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= CMAX;
      else if (clear)          cnt_q <= '0;
      else if (cnt_q != CMAX)  cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (GAP_SRC == 0) begin : g_timer
         wire unused_int = int_n;
         assign done = need_conv ? (cnt_q >= GCW'(GAP_CYC)) : (cnt_q >= GCW'(MIN_GAP));
         assign tmo  = 1'b0;
      end else begin : g_irq
         assign done = (cnt_q >= GCW'(MIN_GAP)) && (!need_conv || !int_n);
         assign tmo  = need_conv && int_n && (cnt_q >= GCW'(TMO_CYC));
      end
   endgenerate
endmodule

// File: rtl/adcrd_out_stage.sv
module adcrd_out_stage #(
   parameter int DW = 8,
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] ld_data,
   input  logic [AW-1:0] ld_chan,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] data,
   output logic [AW-1:0] chan
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
         chan  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= ld_data;
         chan  <= ld_chan;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl #(
   parameter int NCH     = 8,
   parameter int DW      = 8,
   parameter int RD_CYC  = 4,
   parameter int GAP_CYC = 250,
   parameter int MIN_GAP = 2,
   parameter int TMO_CYC = 1000,
   parameter int GAP_SRC = 0,
   localparam int AW     = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           mode_i,
   input  logic [NCH-1:0] scan_mask_i,
   output logic           adc_cs_n_o,
   output logic           adc_rd_n_o,
   output logic [AW-1:0]  adc_addr_o,
   input  logic [DW-1:0]  adc_data_i,
   input  logic           adc_rdy_i,
   input  logic           adc_int_n_i,
   output logic           smp_valid_o,
   input  logic           smp_ready_i,
   output logic [DW-1:0]  smp_data_o,
   output logic [AW-1:0]  smp_chan_o,
   output logic           busy_o,
   output logic           err_o
);
   import adcrd_pkg::*;

   localparam int RCW = $clog2(TMO_CYC + 2);

   // elaboration-time parameter checks
   if (NCH < 2)                       begin : g_bad_nch  $error("NCH must be at least 2"); end
   if (DW < 1)                        begin : g_bad_dw   $error("DW must be positive"); end
   if (RD_CYC < 3)                    begin : g_bad_rd   $error("RD_CYC must be at least 3"); end
   if (MIN_GAP < 1)                   begin : g_bad_min  $error("MIN_GAP must be positive"); end
   if (GAP_CYC < MIN_GAP)             begin : g_bad_gap  $error("GAP_CYC below MIN_GAP"); end
   if (TMO_CYC <= RD_CYC)             begin : g_bad_tmo  $error("TMO_CYC must exceed RD_CYC"); end
   if (GAP_SRC != 0 && GAP_SRC != 1)  begin : g_bad_src  $error("GAP_SRC must be 0 or 1"); end

   adcrd_state_e   state_q;
   logic [NCH-1:0] mask_q;
   logic [AW-1:0]  cur_q, tag_q;
   logic           pmode_q, have_tag_q, flush_q, conv_pend_q, err_q, bus_lo_q;
   logic [RCW-1:0] rcnt_q;

   logic [NCH-1:0] pick_mask;
   logic [AW-1:0]  pick_ch;
   logic           pick_found, pick_from0;
   logic           gap_done, gap_tmo;
   logic           launch, cap, abort_rd, emit;
   logic [AW-1:0]  emit_ch;

   assign pick_from0 = (state_q == ST_IDLE);
   assign pick_mask  = pick_from0 ? scan_mask_i : mask_q;

   adcrd_chan_pick #(.NCH(NCH), .AW(AW)) u_pick (
      .mask       (pick_mask),
      .cur        (cur_q),
      .from_start (pick_from0),
      .nxt        (pick_ch),
      .found      (pick_found)
   );

   adcrd_gap #(
      .GAP_CYC (GAP_CYC),
      .MIN_GAP (MIN_GAP),
      .TMO_CYC (TMO_CYC),
      .GAP_SRC (GAP_SRC)
   ) u_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .need_conv (conv_pend_q),
      .int_n     (adc_int_n_i),
      .done      (gap_done),
      .tmo       (gap_tmo)
   );

   assign launch   = (state_q == ST_GAP) && gap_done && !gap_tmo && !smp_valid_o;
   assign cap      = (state_q == ST_READ) && (rcnt_q >= RCW'(RD_CYC - 1))
                     && (pmode_q || adc_rdy_i);
   assign abort_rd = (state_q == ST_READ) && !cap && !pmode_q
                     && (rcnt_q >= RCW'(TMO_CYC));
   assign emit     = cap && (!pmode_q || have_tag_q);
   assign emit_ch  = pmode_q ? tag_q : cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         mask_q      <= '0;
         cur_q       <= '0;
         tag_q       <= '0;
         pmode_q     <= 1'b0;
         have_tag_q  <= 1'b0;
         flush_q     <= 1'b0;
         conv_pend_q <= 1'b0;
         err_q       <= 1'b0;
         bus_lo_q    <= 1'b0;
         rcnt_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i && pick_found) begin
                  mask_q     <= scan_mask_i;
                  pmode_q    <= mode_i;
                  cur_q      <= pick_ch;
                  have_tag_q <= 1'b0;
                  flush_q    <= 1'b0;
                  err_q      <= 1'b0;
                  state_q    <= ST_GAP;
               end
            end
            ST_READ: begin
               rcnt_q <= rcnt_q + 1'b1;
               if (cap) begin
                  bus_lo_q    <= 1'b0;
                  conv_pend_q <= pmode_q;
                  if (!pmode_q) begin
                     if (pick_found) begin
                        cur_q   <= pick_ch;
                        state_q <= ST_GAP;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else if (flush_q) begin
                     state_q <= ST_IDLE;
                  end else begin
                     tag_q      <= cur_q;
                     have_tag_q <= 1'b1;
                     if (pick_found) cur_q   <= pick_ch;
                     else            flush_q <= 1'b1;
                     state_q <= ST_GAP;
                  end
               end else if (abort_rd) begin
                  bus_lo_q    <= 1'b0;
                  conv_pend_q <= 1'b1;
                  err_q       <= 1'b1;
                  state_q     <= ST_IDLE;
               end
            end
            ST_GAP: begin
               if (gap_tmo) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (launch) begin
                  bus_lo_q <= 1'b1;
                  rcnt_q   <= '0;
                  state_q  <= ST_READ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   adcrd_out_stage #(.DW(DW), .AW(AW)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (emit),
      .ld_data (adc_data_i),
      .ld_chan (emit_ch),
      .ready   (smp_ready_i),
      .valid   (smp_valid_o),
      .data    (smp_data_o),
      .chan    (smp_chan_o)
   );

   assign adc_cs_n_o = ~bus_lo_q;
   assign adc_rd_n_o = ~bus_lo_q;
   assign adc_addr_o = cur_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign err_o      = err_q;
endmodule

// File: rtl/adcrd_ctrl_chk.sv
module adcrd_ctrl_chk #(
   parameter int AW      = 3,
   parameter int DW      = 8,
   parameter int GAP_CYC = 250,
   parameter int GAP_SRC = 0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          adc_cs_n,
   input logic          adc_rd_n,
   input logic [AW-1:0] adc_addr,
   input logic          adc_rdy,
   input logic          smp_valid,
   input logic          smp_ready,
   input logic [DW-1:0] smp_data,
   input logic [AW-1:0] smp_chan,
   input logic          busy,
   input logic          err,
   input logic          pmode
);
   localparam int GW = $clog2(GAP_CYC + 2);
   localparam logic [GW-1:0] GMAX = {GW{1'b1}};

   logic          rd_q, pipe_last_q, fall_now;
   logic [GW-1:0] gcnt_q;

   assign fall_now = rd_q && !adc_rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q        <= 1'b1;
         pipe_last_q <= 1'b0;
         gcnt_q      <= GMAX;
      end else begin
         rd_q <= adc_rd_n;
         if (!rd_q && adc_rd_n) pipe_last_q <= pmode;
         if (fall_now)            gcnt_q <= GW'(1);
         else if (gcnt_q != GMAX) gcnt_q <= gcnt_q + 1'b1;
      end
   end

   p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (adc_cs_n && adc_rd_n));

   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_addr));

   p_wait_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pmode && $rose(adc_rd_n)) |-> ($past(adc_rdy) || err));

   p_read_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((GAP_SRC == 0) && fall_now && pipe_last_q) |-> (gcnt_q >= GW'(GAP_CYC)));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data) && $stable(smp_chan)));

   p_stall_blocks_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> !$past(smp_valid));

   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (adc_cs_n && !busy));
endmodule

bind adcrd_ctrl adcrd_ctrl_chk #(
   .AW      (AW),
   .DW      (DW),
   .GAP_CYC (GAP_CYC),
   .GAP_SRC (GAP_SRC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adc_cs_n  (adc_cs_n_o),
   .adc_rd_n  (adc_rd_n_o),
   .adc_addr  (adc_addr_o),
   .adc_rdy   (adc_rdy_i),
   .smp_valid (smp_valid_o),
   .smp_ready (smp_ready_i),
   .smp_data  (smp_data_o),
   .smp_chan  (smp_chan_o),
   .busy      (busy_o),
   .err       (err_o),
   .pmode     (pmode_q)
);

// File: tb/tb_adcrd_ctrl.sv
`timescale 1ns/1ps
module tb_adcrd_ctrl;
   localparam int NCH      = 8;
   localparam int DW       = 8;
   localparam int AW       = 3;
   localparam int RD_CYC   = 4;
   localparam int GAP_CYC  = 250;
   localparam int TMO_CYC  = 1000;
   localparam int CONV_CYC = 200;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, mode = 1'b0;
   logic [NCH-1:0] mask = '0;
   logic cs_n, rd_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dbus = '0;
   logic rdy_m = 1'b1, int_n = 1'b1, rdy_stuck = 1'b0;
   logic svalid, sready = 1'b1;
   logic [DW-1:0] sdata;
   logic [AW-1:0] schan;
   logic busy, err;

   always #5 clk = ~clk;

   adcrd_ctrl #(.NCH(NCH), .DW(DW), .RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC),
                .TMO_CYC(TMO_CYC), .GAP_SRC(0)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .scan_mask_i(mask),
      .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n), .adc_addr_o(addr), .adc_data_i(dbus),
      .adc_rdy_i(rdy_m & ~rdy_stuck), .adc_int_n_i(int_n),
      .smp_valid_o(svalid), .smp_ready_i(sready), .smp_data_o(sdata), .smp_chan_o(schan),
      .busy_o(busy), .err_o(err));

   function automatic logic [7:0] fval(int a, int k);
      return 8'((a * 37 + k * 11 + 5) & 255);
   endfunction

   // converter model: one result register, conversion of CONV_CYC cycles
   logic        m_prev_hi = 1'b1;
   int          m_left = 0, m_addr = 0, m_k = 0, m_kcnt = 0;
   logic [7:0]  m_last = '0;
   always @(posedge clk) begin
      if (!cs_n && !rd_n && m_prev_hi) begin
         dbus   <= m_last;
         m_left <= CONV_CYC;
         m_addr <= int'(addr);
         m_k    <= m_kcnt;
         m_kcnt <= m_kcnt + 1;
         int_n  <= 1'b1;
         rdy_m  <= 1'b0;
      end else begin
         if (m_left > 0) begin
            m_left <= m_left - 1;
            if (m_left == 1) begin
               m_last <= fval(m_addr, m_k);
               int_n  <= 1'b0;
               if (!cs_n && !rd_n) begin
                  dbus  <= fval(m_addr, m_k);
                  rdy_m <= 1'b1;
               end
            end
         end
         if (cs_n) rdy_m <= 1'b1;
      end
      m_prev_hi <= !(!cs_n && !rd_n);
   end

   int checks = 0, fails = 0, cyc = 0, kexp = 0;
   int exp_ch[$], exp_dt[$];
   int rmode = 0;
   int fall_cnt = 0, last_fall = 0, min_gap = 0, min_low = 0;
   logic first_in_scan = 1'b1, prev_rd = 1'b1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // stream ready pattern, changed just after each rising edge
   initial forever begin
      @(posedge clk); #1;
      case (rmode)
         0: sready = 1'b1;
         1: sready = ~sready;
         default: sready = 1'b0;
      endcase
   end

   // monitor: scoreboard pop and bus timing measurement
   always @(negedge clk) begin
      if (rst_n && svalid && sready) begin
         if (exp_ch.size() == 0) begin
            check(1'b0, "R2 unexpected sample", int'(schan), -1);
         end else begin
            int ec, ed;
            ec = exp_ch.pop_front();
            ed = exp_dt.pop_front();
            check(int'(schan) == ec, "R2/R5 channel tag", int'(schan), ec);
            check(int'(sdata) == ed, "R4/R5 sample value", int'(sdata), ed);
         end
      end
      if (prev_rd && !rd_n) begin
         fall_cnt++;
         if (!first_in_scan && (cyc - last_fall) < min_gap) min_gap = cyc - last_fall;
         first_in_scan = 1'b0;
         last_fall = cyc;
      end
      if (!prev_rd && rd_n && (cyc - last_fall) < min_low) min_low = cyc - last_fall;
      prev_rd = rd_n;
   end

   task automatic pulse_start(input logic [NCH-1:0] m, input logic md);
      @(posedge clk); #1;
      mask = m; mode = md; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic push_scan(input logic [NCH-1:0] m, input logic md, output int n);
      n = 0;
      for (int c = 0; c < NCH; c++) begin
         if (m[c]) begin
            exp_ch.push_back(c);
            exp_dt.push_back(int'(fval(c, kexp + n)));
            n++;
         end
      end
      kexp += n + (md ? 1 : 0);
      min_gap = 1 << 30; min_low = 1 << 30; first_in_scan = 1'b1;
   endtask

   task automatic wait_drain();
      @(negedge clk);
      while (busy || svalid || exp_ch.size() != 0) @(negedge clk);
   endtask

   task automatic run_scan(input logic [NCH-1:0] m, input logic md);
      int n, f0;
      push_scan(m, md, n);
      f0 = fall_cnt;
      pulse_start(m, md);
      wait_drain();
      check(fall_cnt - f0 == n + (md ? 1 : 0), md ? "R5 read count" : "R2 read count",
            fall_cnt - f0, n + (md ? 1 : 0));
      check(err == 1'b0, "R8 err clear after good scan", int'(err), 0);
      if (md && n > 0) check(min_gap >= GAP_CYC, "R6 pipelined read spacing", min_gap, GAP_CYC);
      if (!md) check(min_low >= CONV_CYC, "R4 strobe held until ready", min_low, CONV_CYC);
   endtask

   logic done = 1'b0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog act=hung exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n, f0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(cs_n && rd_n, "R1 bus idle after reset", int'({cs_n, rd_n}), 3);
      check(!svalid && !busy && !err, "R1 flags low after reset", int'({svalid, busy, err}), 0);

      run_scan(8'hFF, 1'b0);          // R2 R4 full wait-state scan
      run_scan(8'hFF, 1'b1);          // R5 R6 full pipelined scan
      rmode = 1;
      run_scan(8'hA5, 1'b1);          // R5 R7 sparse mask, toggling ready
      rmode = 0;

      // R9 start while busy ignored: wait-state scan with a second start pulse
      push_scan(8'h81, 1'b0, n);
      f0 = fall_cnt;
      pulse_start(8'h81, 1'b0);
      repeat (20) @(posedge clk);
      pulse_start(8'hFF, 1'b1);
      wait_drain();
      check(fall_cnt - f0 == 2, "R9 start while busy ignored", fall_cnt - f0, 2);

      run_scan(8'h08, 1'b1);          // R5 single channel: two reads, one sample

      // R7 stall holds off the next read
      push_scan(8'h0E, 1'b0, n);
      rmode = 2;
      pulse_start(8'h0E, 1'b0);
      @(negedge clk);
      while (!svalid) @(negedge clk);
      f0 = fall_cnt;
      repeat (3000) @(negedge clk);
      check(svalid == 1'b1, "R7 valid held under stall", int'(svalid), 1);
      check(int'(schan) == 1, "R7 channel held under stall", int'(schan), 1);
      check(fall_cnt == f0, "R7 no read while stalled", fall_cnt - f0, 0);
      rmode = 0;
      wait_drain();

      // R8 timeout on ready
      rdy_stuck = 1'b1;
      kexp += 1;
      pulse_start(8'h10, 1'b0);
      @(negedge clk);
      while (busy) @(negedge clk);
      check(err == 1'b1, "R8 err raised on timeout", int'(err), 1);
      check(cs_n && rd_n, "R8 bus released on timeout", int'({cs_n, rd_n}), 3);
      check(!svalid, "R8 no sample on timeout", int'(svalid), 0);
      rdy_stuck = 1'b0;

      // R9 empty mask ignored
      f0 = fall_cnt;
      pulse_start('0, 1'b1);
      repeat (5) @(negedge clk);
      check(!busy && fall_cnt == f0, "R9 empty mask ignored", int'(busy), 0);
      check(err == 1'b1, "R9 empty mask leaves err", int'(err), 1);

      run_scan(8'h06, 1'b1);          // R8 err cleared by next start, R5
      run_scan(8'h01, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule